// File: doc/BRIEF.md
# Epoch-Offset Seconds Clock

This block keeps wall-clock time as a count of seconds since the start of 1904. Internally it never rewrites a running time counter. A prescaler divides the core clock down to one pulse per second. That pulse advances a free-running 32-bit uptime count. A separate 32-bit offset register holds the difference between wall time and uptime, so the time reported is always offset plus uptime, taken modulo 2^32.

Software reaches the block through two command strobes. A read request with an empty argument list returns the current time one cycle later as a 32-bit word. Its first transmitted byte sits in bits 31:24. A write request carries exactly four argument bytes, the first byte in bits 31:24. It loads the offset so that a read made within the same second returns the written value. Any request with the wrong argument count is dropped.

The one-second pulse is also brought out as a single-cycle tick for the interrupt logic. Its period is fixed by the prescaler alone, so servicing latency never accumulates as drift. At reset the offset is loaded with a boot-time Unix seconds parameter plus 2082844800, which is the number of seconds between the two epochs.

Top module: `epoch_seconds_clock`

## Requirements
- R1: While and right after reset, `rsp_valid` and `tick` are 0, uptime is 0, and the offset equals `BOOT_UNIX_SECS + 2082844800` modulo 2^32. A read issued just after reset returns that offset value.
- R2: `tick` is a single-cycle pulse. It is high exactly in the cycles where the number of clock edges since reset release, n, satisfies n mod `TICKS_PER_SEC` = `TICKS_PER_SEC`-1. No other event changes this spacing.
- R3: The uptime advances by exactly one on the edge that ends a `tick` cycle, and it is unchanged on every other edge. It wraps modulo 2^32.
- R4: A read request (`get_valid`=1, `get_len`=0) makes `rsp_valid` high for one cycle after the edge that samples it. `rsp_data` then holds offset plus uptime as both stood at that edge, with the first byte of the four-byte reply in bits 31:24.
- R5: A read request with `get_len` not equal to 0 is ignored, and `rsp_valid` stays 0 in the following cycle.
- R6: A write request (`set_valid`=1, `set_len`=4) makes the offset equal to `set_arg` minus the current uptime, with the first argument byte in bits 31:24. Every later read returns `set_arg` plus the number of seconds elapsed since the write.
- R7: A write request with `set_len` not equal to 4 is ignored and leaves the offset unchanged, as seen by later reads.
- R8: When a read and a valid write are sampled on the same edge, the reply reports the time as it stood before the write.
- R9: Offset and time arithmetic is modulo 2^32. Writing a value smaller than the current uptime, or the value 0xFFFFFFFF, still reads back correctly.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| set_valid | input | 1 | Write-time request strobe |
| set_len | input | 8 | Argument byte count of the write request |
| set_arg | input | 32 | Time to write, first byte in bits 31:24 |
| get_valid | input | 1 | Read-time request strobe |
| get_len | input | 8 | Argument byte count of the read request |
| rsp_valid | output | 1 | Reply valid, one cycle |
| rsp_data | output | 32 | Current time in seconds since 1904, first byte in bits 31:24 |
| tick | output | 1 | One-cycle pulse once per second |

## Verification
The assertions assume that the request strobes and lengths are known values on every sampled edge outside reset. They also assume that `TICKS_PER_SEC` is at least 2, so that a tick pulse can be told apart from a steady level. The stimulus drives every input on the falling edge and returns the strobes to 0 after one cycle, so no request lasts longer than intended. It issues reads at every prescaler phase, including reads in tick cycles, and it pairs a read with a write on one edge. This covers the moments when uptime and offset change at the same time as a reply is captured.

// File: rtl/esc_pkg.sv
package esc_pkg;
    localparam int TIME_W = 32;
    localparam int LEN_W  = 8;
    localparam logic [TIME_W-1:0] EPOCH_GAP = 32'd2082844800;

    typedef logic [TIME_W-1:0] secs_t;

    typedef struct packed {
        logic            valid;
        logic [LEN_W-1:0] len;
        secs_t           arg;
    } set_req_t;

    typedef struct packed {
        logic            valid;
        logic [LEN_W-1:0] len;
    } get_req_t;

    function automatic secs_t boot_offset(input secs_t unix_secs);
        return unix_secs + EPOCH_GAP;
    endfunction

    function automatic logic set_ok(input set_req_t r);
        return r.valid && (r.len == LEN_W'(4));
    endfunction

    function automatic logic get_ok(input get_req_t r);
        return r.valid && (r.len == '0);
    endfunction
endpackage

// File: rtl/esc_prescaler.sv
module esc_prescaler #(
    parameter int TICKS_PER_SEC = 32768
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    localparam int CW = (TICKS_PER_SEC > 1) ? $clog2(TICKS_PER_SEC) : 1;
    localparam logic [CW-1:0] LAST = CW'(TICKS_PER_SEC - 1);

    logic [CW-1:0] phase_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= '0;
        end else if (phase_q == LAST) begin
            phase_q <= '0;
        end else begin
            phase_q <= phase_q + CW'(1);
        end
    end

    assign tick = !rst && (phase_q == LAST);

    generate
        if (TICKS_PER_SEC > 1) begin : g_pulse_chk
            a_r2_single_pulse: assert property (@(posedge clk) disable iff (rst)
                tick |=> !tick);
        end
    endgenerate
endmodule

// File: rtl/esc_uptime.sv
module esc_uptime
    import esc_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  step,
    output secs_t uptime
);
    secs_t count_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            count_q <= '0;
        end else if (step) begin
            count_q <= count_q + secs_t'(1);
        end
    end

    assign uptime = count_q;

    a_r3_hold_between_ticks: assert property (@(posedge clk) disable iff (rst)
        !step |=> $stable(uptime));
    a_r3_advance_on_tick: assert property (@(posedge clk) disable iff (rst)
        step |=> (uptime == $past(uptime) + secs_t'(1)));
endmodule

// File: rtl/esc_cmd.sv
module esc_cmd
    import esc_pkg::*;
#(
    parameter logic [31:0] BOOT_UNIX_SECS = 32'd0
) (
    input  logic     clk,
    input  logic     rst,
    input  set_req_t set_req,
    input  get_req_t get_req,
    input  secs_t    uptime,
    output logic     rsp_valid,
    output secs_t    rsp_data
);
    localparam secs_t RESET_OFFSET = boot_offset(BOOT_UNIX_SECS);

    secs_t offset_q;
    logic  do_set;
    logic  do_get;

    assign do_set = set_ok(set_req);
    assign do_get = get_ok(get_req);

    always_ff @(posedge clk) begin
        if (rst) begin
            offset_q  <= RESET_OFFSET;
            rsp_valid <= 1'b0;
            rsp_data  <= '0;
        end else begin
            rsp_valid <= do_get;
            if (do_get) begin
                rsp_data <= offset_q + uptime;
            end
            if (do_set) begin
                offset_q <= set_req.arg - uptime;
            end
        end
    end

    a_r7_offset_hold: assert property (@(posedge clk) disable iff (rst)
        !do_set |=> $stable(offset_q));
    a_r4_reply_follows: assert property (@(posedge clk) disable iff (rst)
        do_get |=> rsp_valid);
    a_r5_no_stray_reply: assert property (@(posedge clk) disable iff (rst)
        !do_get |=> !rsp_valid);
endmodule

// File: rtl/epoch_seconds_clock.sv
module epoch_seconds_clock
    import esc_pkg::*;
#(
    parameter int          TICKS_PER_SEC  = 32768,
    parameter logic [31:0] BOOT_UNIX_SECS = 32'd0
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        set_valid,
    input  logic [7:0]  set_len,
    input  logic [31:0] set_arg,
    input  logic        get_valid,
    input  logic [7:0]  get_len,
    output logic        rsp_valid,
    output logic [31:0] rsp_data,
    output logic        tick
);
    set_req_t set_req;
    get_req_t get_req;
    secs_t    uptime;
    logic     sec_pulse;

    assign set_req = '{valid: set_valid, len: set_len, arg: set_arg};
    assign get_req = '{valid: get_valid, len: get_len};

    esc_prescaler #(.TICKS_PER_SEC(TICKS_PER_SEC)) u_div (
        .clk  (clk),
        .rst  (rst),
        .tick (sec_pulse)
    );

    esc_uptime u_up (
        .clk    (clk),
        .rst    (rst),
        .step   (sec_pulse),
        .uptime (uptime)
    );

    esc_cmd #(.BOOT_UNIX_SECS(BOOT_UNIX_SECS)) u_cmd (
        .clk       (clk),
        .rst       (rst),
        .set_req   (set_req),
        .get_req   (get_req),
        .uptime    (uptime),
        .rsp_valid (rsp_valid),
        .rsp_data  (rsp_data)
    );

    assign tick = sec_pulse;

    a_r1_quiet_after_reset: assert property (@(posedge clk)
        rst |=> (!rsp_valid && !tick));
endmodule

// File: tb/epoch_seconds_clock_tb_top.sv
module epoch_seconds_clock_tb_top;
    localparam int          T    = 5;
    localparam logic [31:0] BOOT = 32'd1000000000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        set_valid = 1'b0;
    logic [7:0]  set_len = '0;
    logic [31:0] set_arg = '0;
    logic        get_valid = 1'b0;
    logic [7:0]  get_len = '0;
    logic        rsp_valid;
    logic [31:0] rsp_data;
    logic        tick;

    int checks = 0;
    int errors = 0;
    int n = 0;
    logic [31:0] off_m;

    always #4 clk = ~clk;

    always @(posedge clk) begin
        if (rst) n <= 0;
        else     n <= n + 1;
    end

    epoch_seconds_clock #(.TICKS_PER_SEC(T), .BOOT_UNIX_SECS(BOOT)) dut_i (
        .clk(clk), .rst(rst),
        .set_valid(set_valid), .set_len(set_len), .set_arg(set_arg),
        .get_valid(get_valid), .get_len(get_len),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data), .tick(tick)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] up_m();
        return 32'(n / T);
    endfunction

    // one read request; expected value taken at the sampling edge
    task automatic do_get(input logic [7:0] len, input string req);
        logic [31:0] exp;
        exp = off_m + up_m();
        get_valid = 1'b1; get_len = len;
        @(negedge clk);
        get_valid = 1'b0; get_len = '0;
        if (len == 8'd0) begin
            chk(req, {31'd0, rsp_valid}, 32'd1);
            chk(req, rsp_data, exp);
        end else begin
            chk(req, {31'd0, rsp_valid}, 32'd0);
        end
    endtask

    task automatic do_set(input logic [7:0] len, input logic [31:0] arg);
        set_valid = 1'b1; set_len = len; set_arg = arg;
        if (len == 8'd4) off_m = arg - up_m();
        @(negedge clk);
        set_valid = 1'b0; set_len = '0; set_arg = '0;
    endtask

    initial begin
        off_m = BOOT + 32'd2082844800;
        repeat (3) @(negedge clk);
        chk("R1 rsp_valid in reset", {31'd0, rsp_valid}, 32'd0);
        chk("R1 tick in reset", {31'd0, tick}, 32'd0);
        rst = 1'b0;
        @(negedge clk);
        // R1: first read right after reset shows boot offset (uptime 0)
        chk("R1 uptime zero", up_m(), 32'd0);
        do_get(8'd0, "R1 boot offset read");

        // R2: tick spacing sweep over several seconds
        for (int i = 0; i < 4 * T; i++) begin
            chk("R2 tick phase", {31'd0, tick}, {31'd0, (n % T) == T - 1});
            @(negedge clk);
        end

        // R4/R3: reads at every prescaler phase
        for (int i = 0; i < 3 * T; i++) begin
            do_get(8'd0, "R4 R3 read at phase");
        end

        // R5: reads with nonzero length
        do_get(8'd1, "R5 get len 1");
        do_get(8'd4, "R5 get len 4");
        do_get(8'd255, "R5 get len 255");

        // R6: valid writes, then reads across seconds
        do_set(8'd4, 32'h1234_5678);
        for (int i = 0; i < 2 * T; i++) do_get(8'd0, "R6 read after set");
        do_set(8'd4, 32'hFFFF_FFFF);
        for (int i = 0; i < 2 * T; i++) do_get(8'd0, "R9 wrap past all-ones");
        do_set(8'd4, 32'd0);
        for (int i = 0; i < T; i++) do_get(8'd0, "R9 set below uptime");

        // R7: invalid write lengths leave the offset alone
        do_set(8'd0, 32'hDEAD_BEEF);
        do_get(8'd0, "R7 set len 0 ignored");
        do_set(8'd3, 32'hDEAD_BEEF);
        do_get(8'd0, "R7 set len 3 ignored");
        do_set(8'd5, 32'hDEAD_BEEF);
        do_get(8'd0, "R7 set len 5 ignored");

        // R8: read and write on the same edge, at every phase
        for (int i = 0; i < T; i++) begin
            logic [31:0] exp;
            exp = off_m + up_m();
            set_valid = 1'b1; set_len = 8'd4; set_arg = 32'hA000_0000 + 32'(i);
            get_valid = 1'b1; get_len = 8'd0;
            off_m = set_arg - up_m();
            @(negedge clk);
            set_valid = 1'b0; set_len = '0; set_arg = '0;
            get_valid = 1'b0;
            chk("R8 rsp_valid", {31'd0, rsp_valid}, 32'd1);
            chk("R8 pre-write time", rsp_data, exp);
            do_get(8'd0, "R8 read after combined");
        end

        // R2: tick spacing unaffected by the traffic above
        for (int i = 0; i < 2 * T; i++) begin
            chk("R2 tick phase late", {31'd0, tick}, {31'd0, (n % T) == T - 1});
            @(negedge clk);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #200000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule